// File: doc/BRIEF.md
# Flash External-Programming Command Controller

This block sits between an external device programmer and an embedded flash array. The programmer puts a 4-bit command on two 2-bit fields, an address on a 16-bit bus and, for programming, a byte on a shared bidirectional data bus. It then pulls an active-low strobe low. The controller brings the strobe's falling edge into its own clock domain and launches a self-timed erase or program cycle. It holds a ready output low while that cycle runs. Read-type commands (signature read and byte verify) are combinational. They answer from the live address and command whenever the output enable is low, whatever the level of the strobe.

The storage is a byte-array model of two regions. The primary region starts at address 0000h. The secondary region starts at F000h. Both depths are parameters. The defaults are scaled down to 512 and 256 bytes, and the full 16K/32K and 4K sizes are reached by parameter. Each region has its own security lock. Erases come in three levels: whole chip, one region, or one sector. Sectors are 128 bytes in the primary region and 64 bytes in the secondary one. A region lock blocks region erase, sector erase and byte program for that region. A chip erase clears everything, locks included.

Top module: `flash_prog_ctrl`

## Requirements
- R1: With command code {hi,lo} = 0000, reading address 0030h returns BFh. Address 0031h returns the device code: E4h when LARGE_PRI=0, E2h when LARGE_PRI=1. Any other address returns FFh.
- R2: Read-type commands (0000 signature, 0011 verify) drive the data bus whenever host_oe_n is low. The value depends only on the live command and address. It does not depend on the strobe level or on a cycle in progress.
- R3: A falling edge of prog_strobe_n on a timed command drives ready low for exactly PROG_CYC clocks (program 0111, lock 1111) or ERASE_CYC clocks (erases). A strobe edge on a read-type command never drives ready low.
- R4: Strobe edges that arrive while ready is low are ignored. Commands, addresses and data that change during a cycle have no effect.
- R5: Chip erase (0001) sets every byte of both regions to FFh and clears both locks, even when the locks are set.
- R6: Region erase (1101) erases the whole primary region when A15=0. It erases the whole secondary region when A[15:12]=Fh. Any other address erases nothing.
- R7: Sector erase (1011) sets to FFh the 128-byte aligned sector holding the address (matching A[15:7]) in the primary region, or the 64-byte aligned sector (matching A[15:6]) in the secondary region. Bytes outside that sector are unchanged.
- R8: When the lock of the targeted region is set, region erase, sector erase and byte program leave every byte unchanged.
- R9: Byte program (0111) stores the bitwise AND of the old byte and the bus data at a mapped address.
- R10: Byte verify (0011) returns the stored byte at a mapped address and FFh at an unmapped address.
- R11: Lock set (1111) sets the primary lock when A15=0 and the secondary lock when A[15:12]=Fh.
- R12: After reset, ready is high, both locks are clear and every byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cmd_hi | input | 2 | Upper command field |
| host_cmd_lo | input | 2 | Lower command field |
| host_addr | input | 16 | Byte address / region and sector select |
| host_data | inout | 8 | Program data in, read data out |
| host_oe_n | input | 1 | Active-low output enable for read-type commands |
| prog_strobe_n | input | 1 | Active-low launch strobe; falling edge starts a cycle |
| ready | output | 1 | High when idle, low while a cycle runs |

## Verification
A wrong latched address or command, or a wrong region or sector decode, commits at the end of the cycle. It therefore shows up at the first verify read after ready returns high, as bytes erased one sector too far or not erased at all. The bench sweeps every byte after each operation for this reason. A wrong lock state is hidden until the next region erase, sector erase or program. The bench follows each lock and chip erase with such an operation and a sweep. A timer fault shows at once as a ready-low window of the wrong length. The bench counts this window on every timed command.

// File: rtl/flash_prog_pkg.sv
// Package: command codes and command-class helpers shared by the controller.
// Codes are the concatenation {host_cmd_hi, host_cmd_lo}.
package flash_prog_pkg;
    localparam logic [3:0] CMD_SIG    = 4'b0000;
    localparam logic [3:0] CMD_CHIP   = 4'b0001;
    localparam logic [3:0] CMD_VERIFY = 4'b0011;
    localparam logic [3:0] CMD_PROG   = 4'b0111;
    localparam logic [3:0] CMD_SECTOR = 4'b1011;
    localparam logic [3:0] CMD_REGION = 4'b1101;
    localparam logic [3:0] CMD_LOCK   = 4'b1111;

    localparam logic [7:0] SIG_MAKER  = 8'hBF;
    localparam logic [7:0] DEV_SMALL  = 8'hE4;
    localparam logic [7:0] DEV_LARGE  = 8'hE2;
    localparam logic [15:0] SEC_BASE  = 16'hF000;

    // True for commands that launch a self-timed cycle.
    function automatic logic is_timed(input logic [3:0] c);
        return (c == CMD_CHIP) || (c == CMD_REGION) || (c == CMD_SECTOR) ||
               (c == CMD_PROG) || (c == CMD_LOCK);
    endfunction

    // True for commands that use the long erase timing.
    function automatic logic is_erase(input logic [3:0] c);
        return (c == CMD_CHIP) || (c == CMD_REGION) || (c == CMD_SECTOR);
    endfunction
endpackage

// File: rtl/flash_strobe_sync.sv
// Strobe synchronizer: brings the asynchronous active-low launch strobe into
// the clock domain through two flops and emits a one-cycle pulse on its
// falling edge. Assumes the strobe stays low for at least two clocks.
module flash_strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall_pulse
);
    logic meta_q, sync_q, prev_q;

    // Two-flop synchronizer plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= strobe_n;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Falling edge of the synchronized strobe.
    assign fall_pulse = prev_q & ~sync_q;

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |=> !fall_pulse);
endmodule

// File: rtl/flash_seq.sv
// Cycle sequencer: on a launch pulse while idle with a timed command, captures
// command, address and data and runs a down-counter for PROG_CYC or
// ERASE_CYC clocks. commit is high in the last busy cycle, when the storage
// applies the operation. Launch pulses while busy are dropped.
module flash_seq #(
    parameter int PROG_CYC  = 64,
    parameter int ERASE_CYC = 256,
    parameter int AW        = 16,
    parameter int DW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [3:0]    cmd_in,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          busy,
    output logic          commit,
    output logic [3:0]    lat_cmd,
    output logic [AW-1:0] lat_addr,
    output logic [DW-1:0] lat_data
);
    import flash_prog_pkg::*;

    localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;
    logic          start;

    assign start  = !busy && launch && is_timed(cmd_in);
    assign commit = busy && (cnt_q == '0);

    // Busy flag, cycle timer and launch-time capture of the command operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt_q    <= '0;
            lat_cmd  <= CMD_SIG;
            lat_addr <= '0;
            lat_data <= '0;
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end else if (start) begin
            busy     <= 1'b1;
            cnt_q    <= is_erase(cmd_in) ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
            lat_cmd  <= cmd_in;
            lat_addr <= addr_in;
            lat_data <= data_in;
        end
    end

    assert_launch_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && launch && is_timed(cmd_in)) |=> busy);
    assert_untimed_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(launch && is_timed(cmd_in))) |=> !busy);
    assert_busy_holds_operands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(lat_cmd) && $stable(lat_addr) && $stable(lat_data)));
endmodule

// File: rtl/flash_store.sv
// Byte-array storage: a primary region at 0000h of PRI_DEPTH bytes and a
// secondary region at F000h of SEC_DEPTH bytes, each with a security lock.
// On commit it applies the latched command: chip, region or sector erase,
// AND-program, or lock set. Verify reads are combinational from a live
// address. Assumes PRI_DEPTH is a multiple of 128 and SEC_DEPTH of 64.
module flash_store #(
    parameter int PRI_DEPTH = 512,
    parameter int SEC_DEPTH = 256,
    parameter int AW        = 16,
    parameter int DW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [3:0]    op_cmd,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] op_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    import flash_prog_pkg::*;

    localparam int N  = PRI_DEPTH + SEC_DEPTH;
    localparam int IW = $clog2(N);
    localparam int PW = $clog2(PRI_DEPTH);
    localparam int SW = $clog2(SEC_DEPTH);

    logic [DW-1:0] mem [N];
    logic          lock_pri, lock_sec;
    logic          tgt_pri, tgt_sec;
    logic          rd_in_pri, rd_in_sec;
    logic [IW-1:0] rd_idx;

    // Address of storage slot i in the host address map.
    function automatic logic [AW-1:0] slot_addr(input int i);
        if (i < PRI_DEPTH) return AW'(i);
        return AW'(SEC_BASE) + AW'(i - PRI_DEPTH);
    endfunction

    // Region targeted by the latched address.
    assign tgt_pri = !op_addr[15];
    assign tgt_sec = (op_addr[15:12] == 4'hF);

    // Apply the committed operation to the array and the locks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem[i] <= '1;
            lock_pri <= 1'b0;
            lock_sec <= 1'b0;
        end else if (commit) begin
            case (op_cmd)
                CMD_CHIP: begin
                    for (int i = 0; i < N; i++) mem[i] <= '1;
                    lock_pri <= 1'b0;
                    lock_sec <= 1'b0;
                end
                CMD_REGION: begin
                    for (int i = 0; i < N; i++) begin
                        if (i < PRI_DEPTH) begin
                            if (tgt_pri && !lock_pri) mem[i] <= '1;
                        end else begin
                            if (tgt_sec && !lock_sec) mem[i] <= '1;
                        end
                    end
                end
                CMD_SECTOR: begin
                    for (int i = 0; i < N; i++) begin
                        if (i < PRI_DEPTH) begin
                            if (tgt_pri && !lock_pri &&
                                slot_addr(i)[15:7] == op_addr[15:7]) mem[i] <= '1;
                        end else begin
                            if (tgt_sec && !lock_sec &&
                                slot_addr(i)[15:6] == op_addr[15:6]) mem[i] <= '1;
                        end
                    end
                end
                CMD_PROG: begin
                    for (int i = 0; i < N; i++) begin
                        if (slot_addr(i) == op_addr &&
                            !((i < PRI_DEPTH) ? lock_pri : lock_sec))
                            mem[i] <= mem[i] & op_data;
                    end
                end
                CMD_LOCK: begin
                    if (tgt_pri) lock_pri <= 1'b1;
                    if (tgt_sec) lock_sec <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Verify read path: map the live address to a slot, or report unmapped.
    always_comb begin
        rd_in_pri = !rd_addr[15] && (rd_addr < AW'(PRI_DEPTH));
        rd_in_sec = (rd_addr[15:12] == 4'hF) &&
                    ({4'h0, rd_addr[11:0]} < AW'(SEC_DEPTH));
        if (rd_in_pri) rd_idx = IW'(rd_addr[PW-1:0]);
        else           rd_idx = IW'(PRI_DEPTH) + IW'(rd_addr[SW-1:0]);
        rd_data = (rd_in_pri || rd_in_sec) ? mem[rd_idx] : '1;
    end

    assert_chip_clears_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op_cmd == CMD_CHIP) |=> (!lock_pri && !lock_sec));
    assert_locked_primary_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op_cmd != CMD_CHIP && tgt_pri && lock_pri) |=> $stable(mem[0]));
    assert_locks_move_on_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(lock_pri) && $stable(lock_sec)));
    assert_array_moves_on_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(mem[0]) && $stable(mem[N-1])));
endmodule

// File: rtl/flash_read_path.sv
// Read path: picks signature bytes or verify data from the live command and
// address and decides when the block drives the shared data bus. Purely
// combinational, so the strobe and any running cycle do not affect it.
module flash_read_path #(
    parameter bit LARGE_PRI = 1'b0,
    parameter int AW        = 16,
    parameter int DW        = 8
) (
    input  logic [3:0]    cmd,
    input  logic [AW-1:0] addr,
    input  logic          oe_n,
    input  logic [DW-1:0] verify_data,
    output logic          drive_en,
    output logic [DW-1:0] out_data
);
    import flash_prog_pkg::*;

    logic [7:0] dev_code;
    logic [7:0] sig_byte;

    // Device code chosen by the size variant.
    if (LARGE_PRI) begin : g_large
        assign dev_code = DEV_LARGE;
    end else begin : g_small
        assign dev_code = DEV_SMALL;
    end

    // Signature byte lookup, FFh outside the two signature addresses.
    always_comb begin
        if (addr == AW'(16'h0030))      sig_byte = SIG_MAKER;
        else if (addr == AW'(16'h0031)) sig_byte = dev_code;
        else                            sig_byte = 8'hFF;
    end

    // Bus drive and output data selection.
    assign drive_en = !oe_n && ((cmd == CMD_SIG) || (cmd == CMD_VERIFY));
    assign out_data = (cmd == CMD_SIG) ? DW'(sig_byte) : verify_data;

    always_comb begin
        if (!oe_n && cmd == CMD_SIG && addr == AW'(16'h0030))
            assert_sig_maker_R1: assert (out_data == DW'(SIG_MAKER));
    end
endmodule

// File: rtl/flash_prog_ctrl.sv
// Top: external-programming command controller. Joins the strobe
// synchronizer, cycle sequencer, storage and read path, and drives the
// shared data bus only for read-type commands with output enable low.
module flash_prog_ctrl #(
    parameter int PRI_DEPTH = 512,
    parameter int SEC_DEPTH = 256,
    parameter int PROG_CYC  = 64,
    parameter int ERASE_CYC = 256,
    parameter bit LARGE_PRI = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  host_cmd_hi,
    input  logic [1:0]  host_cmd_lo,
    input  logic [15:0] host_addr,
    inout  wire  [7:0]  host_data,
    input  logic        host_oe_n,
    input  logic        prog_strobe_n,
    output logic        ready
);
    localparam int AW = 16;
    localparam int DW = 8;

    logic [3:0]    cmd_live;
    logic          launch, busy, commit;
    logic [3:0]    lat_cmd;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_data, ver_data, rd_out;
    logic          drive_en;

    assign cmd_live = {host_cmd_hi, host_cmd_lo};

    flash_strobe_sync sync_i (
        .clk(clk), .rst_n(rst_n), .strobe_n(prog_strobe_n), .fall_pulse(launch)
    );

    flash_seq #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .AW(AW), .DW(DW)) seq_i (
        .clk(clk), .rst_n(rst_n), .launch(launch), .cmd_in(cmd_live),
        .addr_in(host_addr), .data_in(host_data), .busy(busy), .commit(commit),
        .lat_cmd(lat_cmd), .lat_addr(lat_addr), .lat_data(lat_data)
    );

    flash_store #(.PRI_DEPTH(PRI_DEPTH), .SEC_DEPTH(SEC_DEPTH), .AW(AW), .DW(DW)) store_i (
        .clk(clk), .rst_n(rst_n), .commit(commit), .op_cmd(lat_cmd),
        .op_addr(lat_addr), .op_data(lat_data), .rd_addr(host_addr),
        .rd_data(ver_data)
    );

    flash_read_path #(.LARGE_PRI(LARGE_PRI), .AW(AW), .DW(DW)) rdp_i (
        .cmd(cmd_live), .addr(host_addr), .oe_n(host_oe_n),
        .verify_data(ver_data), .drive_en(drive_en), .out_data(rd_out)
    );

    // Bus driver and ready output.
    assign host_data = drive_en ? rd_out : 'z;
    assign ready     = !busy;

    assert_ready_after_reset_R12: assert property (@(posedge clk)
        !rst_n |=> ready);
endmodule

// File: tb/flash_prog_ctrl_tb_top.sv
// Bench: directed corner cases plus seeded random operations, each checked
// against a byte-level model kept by bench functions.
module flash_prog_ctrl_tb_top;
    localparam int PRI = 512;
    localparam int SEC = 256;
    localparam int PCY = 64;
    localparam int ECY = 256;
    localparam logic [3:0] C_SIG = 4'b0000, C_CHIP = 4'b0001, C_VER = 4'b0011,
                           C_PRG = 4'b0111, C_SECT = 4'b1011, C_REG = 4'b1101,
                           C_LOCK = 4'b1111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]  cmd = C_SIG;
    logic [15:0] addr = '0;
    logic        oe_n = 1'b1;
    logic        strobe_n = 1'b1;
    logic [7:0]  tb_drv = '0;
    logic        tb_drv_en = 1'b1;
    wire  [7:0]  dbus;
    logic        ready;

    assign dbus = tb_drv_en ? tb_drv : 'z;

    flash_prog_ctrl #(.PRI_DEPTH(PRI), .SEC_DEPTH(SEC), .PROG_CYC(PCY),
                      .ERASE_CYC(ECY), .LARGE_PRI(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_cmd_hi(cmd[3:2]), .host_cmd_lo(cmd[1:0]),
        .host_addr(addr), .host_data(dbus), .host_oe_n(oe_n),
        .prog_strobe_n(strobe_n), .ready(ready)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    logic [7:0] m_pri [PRI];
    logic [7:0] m_sec [SEC];
    bit lk_pri, lk_sec;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            finish_run();
        end
    end

    function automatic bit a_pri(input logic [15:0] a);
        return !a[15] && (int'(a) < PRI);
    endfunction
    function automatic bit a_sec(input logic [15:0] a);
        return (a[15:12] == 4'hF) && (int'(a[11:0]) < SEC);
    endfunction

    // Model update following R5..R11.
    task automatic model_apply(input logic [3:0] c, input logic [15:0] a, input logic [7:0] d);
        case (c)
            C_CHIP: begin
                for (int j = 0; j < PRI; j++) m_pri[j] = 8'hFF;
                for (int j = 0; j < SEC; j++) m_sec[j] = 8'hFF;
                lk_pri = 0; lk_sec = 0;
            end
            C_REG: begin
                if (!a[15] && !lk_pri) for (int j = 0; j < PRI; j++) m_pri[j] = 8'hFF;
                if (a[15:12] == 4'hF && !lk_sec) for (int j = 0; j < SEC; j++) m_sec[j] = 8'hFF;
            end
            C_SECT: begin
                if (!a[15] && !lk_pri)
                    for (int j = 0; j < PRI; j++) if (j / 128 == int'(a) / 128) m_pri[j] = 8'hFF;
                if (a[15:12] == 4'hF && !lk_sec)
                    for (int j = 0; j < SEC; j++) if (j / 64 == int'(a[11:0]) / 64) m_sec[j] = 8'hFF;
            end
            C_PRG: begin
                if (a_pri(a) && !lk_pri) m_pri[int'(a)] = m_pri[int'(a)] & d;
                if (a_sec(a) && !lk_sec) m_sec[int'(a[11:0])] = m_sec[int'(a[11:0])] & d;
            end
            C_LOCK: begin
                if (!a[15]) lk_pri = 1;
                if (a[15:12] == 4'hF) lk_sec = 1;
            end
            default: ;
        endcase
    endtask

    // Asynchronous read with the given read-type command.
    task automatic rd(input logic [3:0] c, input logic [15:0] a, output logic [7:0] v);
        cmd = c; addr = a; tb_drv_en = 0; oe_n = 0;
        #2 v = dbus;
        oe_n = 1; tb_drv_en = 1;
    endtask

    // Launch a command; returns clocks with ready low. poke=1 fires a second
    // strobe with a chip-erase command in the middle of the cycle.
    task automatic do_op(input logic [3:0] c, input logic [15:0] a, input logic [7:0] d,
                         input bit poke, output int busy_len);
        int tries;
        @(negedge clk);
        cmd = c; addr = a; tb_drv = d; tb_drv_en = 1; strobe_n = 0;
        busy_len = 0; tries = 0;
        while (ready && tries < 10) begin @(negedge clk); tries++; end
        if (!ready) begin
            busy_len = 1;
            strobe_n = 1;
            for (int k = 0; k < 4000; k++) begin
                @(negedge clk);
                if (poke && k == 3) begin cmd = C_CHIP; addr = 16'h0000; tb_drv = 8'h00; end
                if (poke && k == 6) strobe_n = 0;
                if (poke && k == 10) strobe_n = 1;
                if (ready) break;
                busy_len++;
            end
        end
        strobe_n = 1;
        repeat (4) @(negedge clk);
        model_apply(c, a, d);
    endtask

    // Read every byte with verify and compare with the model.
    task automatic sweep(input string req);
        int bad = 0;
        logic [7:0] v;
        logic [15:0] first_a = '0;
        logic [7:0] first_v = '0, first_e = '0;
        for (int j = 0; j < PRI; j++) begin
            rd(C_VER, 16'(j), v);
            if (v !== m_pri[j]) begin
                if (bad == 0) begin first_a = 16'(j); first_v = v; first_e = m_pri[j]; end
                bad++;
            end
        end
        for (int j = 0; j < SEC; j++) begin
            rd(C_VER, 16'hF000 + 16'(j), v);
            if (v !== m_sec[j]) begin
                if (bad == 0) begin first_a = 16'hF000 + 16'(j); first_v = v; first_e = m_sec[j]; end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s sweep addr=%0h actual=%0h expected=%0h (%0d bytes differ)",
                     req, first_a, first_v, first_e, bad);
        end
    endtask

    initial begin
        int blen;
        int unsigned seed;
        logic [7:0] v;
        logic [15:0] ra;
        logic [3:0] rc;
        int pick;
        seed = $urandom(32'd4242);
        for (int j = 0; j < PRI; j++) m_pri[j] = 8'hFF;
        for (int j = 0; j < SEC; j++) m_sec[j] = 8'hFF;
        lk_pri = 0; lk_sec = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R12: reset state
        check("R12 ready after reset", 32'(ready), 32'd1);
        sweep("R12 erased after reset");

        // R1: signature bytes
        rd(C_SIG, 16'h0030, v); check("R1 maker code", 32'(v), 32'hBF);
        rd(C_SIG, 16'h0031, v); check("R1 device code", 32'(v), 32'hE4);
        rd(C_SIG, 16'h0032, v); check("R1 non-signature addr", 32'(v), 32'hFF);

        // R3: untimed command on a strobe edge never drops ready
        do_op(C_SIG, 16'h0030, 8'h00, 0, blen);
        check("R3 read-type strobe no busy", 32'(blen), 32'd0);

        // R2: read unaffected by strobe level
        strobe_n = 0; #3;
        rd(C_SIG, 16'h0030, v); check("R2 read with strobe low", 32'(v), 32'hBF);
        strobe_n = 1; repeat (6) @(negedge clk);

        // R9 + R3: AND programming, program timing
        do_op(C_PRG, 16'h0010, 8'h5A, 0, blen);
        check("R3 program busy length", 32'(blen), 32'(PCY));
        do_op(C_PRG, 16'h0010, 8'h0F, 0, blen);
        rd(C_VER, 16'h0010, v); check("R9 AND program", 32'(v), 32'h0A);

        // R10: unmapped verify
        rd(C_VER, 16'h2000, v); check("R10 unmapped verify", 32'(v), 32'hFF);
        rd(C_VER, 16'hF000 + 16'(SEC), v); check("R10 unmapped secondary", 32'(v), 32'hFF);

        // R7: sector boundaries in both regions
        do_op(C_PRG, 16'h007F, 8'h00, 0, blen);
        do_op(C_PRG, 16'h0080, 8'h00, 0, blen);
        do_op(C_PRG, 16'h00FF, 8'h00, 0, blen);
        do_op(C_PRG, 16'h0100, 8'h00, 0, blen);
        do_op(C_PRG, 16'hF03F, 8'h00, 0, blen);
        do_op(C_PRG, 16'hF040, 8'h00, 0, blen);
        do_op(C_PRG, 16'hF07F, 8'h00, 0, blen);
        do_op(C_PRG, 16'hF080, 8'h00, 0, blen);
        do_op(C_SECT, 16'h00C5, 8'h00, 0, blen);
        check("R3 erase busy length", 32'(blen), 32'(ECY));
        rd(C_VER, 16'h0080, v); check("R7 primary sector low edge", 32'(v), 32'hFF);
        rd(C_VER, 16'h00FF, v); check("R7 primary sector high edge", 32'(v), 32'hFF);
        rd(C_VER, 16'h007F, v); check("R7 primary below sector kept", 32'(v), 32'h00);
        rd(C_VER, 16'h0100, v); check("R7 primary above sector kept", 32'(v), 32'h00);
        do_op(C_SECT, 16'hF050, 8'h00, 0, blen);
        rd(C_VER, 16'hF040, v); check("R7 secondary sector low edge", 32'(v), 32'hFF);
        rd(C_VER, 16'hF07F, v); check("R7 secondary sector high edge", 32'(v), 32'hFF);
        rd(C_VER, 16'hF03F, v); check("R7 secondary below sector kept", 32'(v), 32'h00);
        rd(C_VER, 16'hF080, v); check("R7 secondary above sector kept", 32'(v), 32'h00);
        sweep("R7 sector erase");

        // R11 + R8: lock primary, then blocked operations
        do_op(C_LOCK, 16'h0000, 8'h00, 0, blen);
        check("R11 lock busy length", 32'(blen), 32'(PCY));
        do_op(C_SECT, 16'h0000, 8'h00, 0, blen);
        rd(C_VER, 16'h007F, v); check("R8 locked sector erase kept", 32'(v), 32'h00);
        do_op(C_REG, 16'h1000, 8'h00, 0, blen);
        rd(C_VER, 16'h0100, v); check("R8 locked region erase kept", 32'(v), 32'h00);
        do_op(C_PRG, 16'h0020, 8'h00, 0, blen);
        rd(C_VER, 16'h0020, v); check("R8 locked program kept", 32'(v), 32'hFF);

        // R6: unlocked secondary region erase, other addresses erase nothing
        do_op(C_REG, 16'hF123, 8'h00, 0, blen);
        rd(C_VER, 16'hF03F, v); check("R6 secondary region erased", 32'(v), 32'hFF);
        do_op(C_PRG, 16'hF001, 8'h00, 0, blen);
        do_op(C_REG, 16'h8000, 8'h00, 0, blen);
        rd(C_VER, 16'hF001, v); check("R6 unmapped region select no erase", 32'(v), 32'h00);
        sweep("R6 R8 R11 locked state");

        // R4: strobe with chip erase during a program cycle is ignored
        do_op(C_PRG, 16'hF002, 8'h33, 1, blen);
        check("R4 busy length unchanged", 32'(blen), 32'(PCY));
        rd(C_VER, 16'hF002, v); check("R4 program applied", 32'(v), 32'h33);
        rd(C_VER, 16'h007F, v); check("R4 no chip erase", 32'(v), 32'h00);

        // R5: chip erase overrides and clears locks
        do_op(C_LOCK, 16'hF000, 8'h00, 0, blen);
        do_op(C_CHIP, 16'h0000, 8'h00, 0, blen);
        check("R5 chip erase busy length", 32'(blen), 32'(ECY));
        sweep("R5 chip erase all FF");
        do_op(C_PRG, 16'h0020, 8'h12, 0, blen);
        rd(C_VER, 16'h0020, v); check("R5 primary lock cleared", 32'(v), 32'h12);
        do_op(C_PRG, 16'hF020, 8'h34, 0, blen);
        rd(C_VER, 16'hF020, v); check("R5 secondary lock cleared", 32'(v), 32'h34);

        // Random mix of R6..R11 against the model
        for (int n = 0; n < 60; n++) begin
            pick = int'($urandom % 20);
            if ($urandom % 2 == 0) ra = 16'($urandom % PRI);
            else                   ra = 16'hF000 + 16'($urandom % SEC);
            if (pick < 12)      rc = C_PRG;
            else if (pick < 16) rc = C_SECT;
            else if (pick < 17) rc = C_REG;
            else if (pick < 18) rc = C_LOCK;
            else                rc = C_CHIP;
            do_op(rc, ra, 8'($urandom), 0, blen);
            if (n % 6 == 5) sweep("R7 R8 R9 R11 random mix");
        end
        sweep("R6 R9 final random");

        finish_run();
    end
endmodule